// File: doc/BRIEF.md
# Unaligned Access Byte Splitter

This block sits between a load/store unit and a memory port. It takes one request at a time and looks at its address, size, access kind, write data, byte order and control bits. From these it decides one of three things. The access may fail with an alignment fault. It may go out as one transaction of its full size. Or it must be broken into single-byte transactions that walk upward from the request address. For a broken-up read, the returned bytes are gathered back into their lanes. The block sends one response when the read data is complete or when the access has ended.

Write data is byte-reversed within the access size when big-endian order is selected, before any transaction is issued. An exclusive access is never allowed to take the byte-by-byte path; it is reported as an error instead. A memory error on any transaction stops the access, and the remaining bytes are not issued. Translation and caching are handled elsewhere. Both the request side and the memory side use plain valid/ready handshakes, and only one request is handled at a time.

Top module: `ubs_top`

## Requirements
- R1: After reset, reqReady is 1 and memValid and rspValid are 0.
- R2: An aligned access of kind normal (0), atomic (1) or ordered (2) is issued as exactly one memory transaction at the request address, with memSizeLog equal to reqSizeLog, and completes with rspCode OK (0).
- R3: An access with reqSizeLog 0 (one byte) is issued as one transaction for every kind, vector (3) and vector-stream (4) included, at any address.
- R4: An unaligned access raises rspCode ALIGN (1) when its kind is atomic or ordered, or when reqAlignChk is 1. No memory transaction is issued, and rspAddr carries the request address.
- R5: Any access of size greater than 1 that is unaligned, or of vector or vector-stream kind, is issued as 2^reqSizeLog transactions with memSizeLog 0. These go in order to address, address+1, and so on, and each write carries its byte in lane 0 (bits 7:0) of memWdata.
- R6: For a split read, the byte returned by transaction i lands in lane i (bits 8i+7:8i) of rspRdata. rspValid rises only after the last byte has returned.
- R7: When reqBigEndian is 1, write byte i of the access is taken from request byte n-1-i, where n is the size. Read data is never reversed, and lanes at or above the size read as zero.
- R8: An exclusive request (reqExcl 1) that would be split completes with rspCode EXCL (2) and issues no transaction. An alignment fault takes precedence over this error.
- R9: A memory error response (memRspErr) on any transaction ends the access with rspCode BUS (3). No further transactions are issued, and rspAddr is the original request address.
- R10: reqReady stays 0 from the accept edge until the response has been given.
- R11: An access is aligned when the address is a multiple of its size, 2^reqSizeLog bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Block idle and able to accept |
| reqAddr | input | ADDR_W | Byte address |
| reqSizeLog | input | SIZE_W | log2 of size in bytes (0..4) |
| reqKind | input | 3 | 0 normal, 1 atomic, 2 ordered, 3 vector, 4 vector-stream |
| reqWrite | input | 1 | 1 for write |
| reqWdata | input | DATA_BYTES*8 | Write data, byte i in lane i |
| reqBigEndian | input | 1 | Reverse write bytes within size |
| reqAlignChk | input | 1 | Fault on any unaligned access |
| reqExcl | input | 1 | Exclusive access |
| rspValid | output | 1 | One-cycle completion pulse |
| rspCode | output | 2 | 0 OK, 1 ALIGN, 2 EXCL, 3 BUS |
| rspRdata | output | DATA_BYTES*8 | Read data (zero for writes) |
| rspAddr | output | ADDR_W | Original request address |
| memValid | output | 1 | Memory transaction valid |
| memReady | input | 1 | Memory accepts transaction |
| memAddr | output | ADDR_W | Transaction address |
| memWrite | output | 1 | Transaction is a write |
| memSizeLog | output | SIZE_W | log2 of transaction size |
| memWdata | output | DATA_BYTES*8 | Transaction write data |
| memRspValid | input | 1 | Memory response pulse |
| memRspErr | input | 1 | Memory response is an error |
| memRdata | input | DATA_BYTES*8 | Memory read data, lane 0 first |

## Verification
The decision is exercised with several kinds of access. Aligned normal and atomic accesses should each go out as one transaction. Byte-sized vector accesses at odd addresses separate the size-1 exception from the vector rule. Aligned vector accesses and unaligned normal accesses should both split, and comparing them shows whether kind and alignment are weighed independently. An address that is a multiple of four but not of eight tests the alignment arithmetic. Big-endian writes are read back in little-endian order, which exposes both the reversal and the order of split bytes. Exclusive and memory-error cases show whether precedence and abort are right: the reference model counts every transaction it expects and flags any extra, with a stalling memory ready.

// File: rtl/ubs_pkg.sv
`timescale 1ns/1ps
package ubs_pkg;

  typedef enum logic [2:0] {
    KIND_NORMAL  = 3'd0,
    KIND_ATOMIC  = 3'd1,
    KIND_ORDERED = 3'd2,
    KIND_VECTOR  = 3'd3,
    KIND_VSTREAM = 3'd4
  } accKind_e;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_ALIGN = 2'd1,
    RSP_EXCL  = 2'd2,
    RSP_BUS   = 2'd3
  } rspCode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } ctlState_e;

  // control -> datapath
  typedef struct packed {
    logic load;       // capture request, clear byte index and read data
    logic incIdx;     // advance to next byte of a split access
    logic capWhole;   // capture a full-width read response
    logic capByte;    // capture one byte of a split read
    logic splitMode;  // memory port shows the byte path
  } ctlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic mustFault;
    logic mustSplit;
    logic isExcl;
    logic lastByte;
  } dpStatus_t;

endpackage

// File: rtl/ubs_datapath.sv
`timescale 1ns/1ps
module ubs_datapath
  import ubs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 16,
  parameter int SIZE_W     = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             strobes,
  output dpStatus_t               status,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [SIZE_W-1:0]       reqSizeLog,
  input  logic [2:0]              reqKind,
  input  logic                    reqWrite,
  input  logic [DATA_BYTES*8-1:0] reqWdata,
  input  logic                    reqBigEndian,
  input  logic                    reqAlignChk,
  input  logic                    reqExcl,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memWrite,
  output logic [SIZE_W-1:0]       memSizeLog,
  output logic [DATA_BYTES*8-1:0] memWdata,
  input  logic [DATA_BYTES*8-1:0] memRdata,
  output logic [DATA_BYTES*8-1:0] rspRdata,
  output logic [ADDR_W-1:0]       rspAddr
);

  localparam int DATA_W = DATA_BYTES * 8;
  localparam int IDX_W  = $clog2(DATA_BYTES);
  localparam int CNT_W  = IDX_W + 1;

  // keep lanes below n, zero the rest
  function automatic logic [DATA_W-1:0] keepLanes(input logic [DATA_W-1:0] d,
                                                  input logic [CNT_W-1:0] n);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int b = 0; b < DATA_BYTES; b++) begin
      if (b < int'(n)) r[b*8 +: 8] = d[b*8 +: 8];
    end
    return r;
  endfunction

  // mirror the lanes below n, zero the rest
  function automatic logic [DATA_W-1:0] mirrorLanes(input logic [DATA_W-1:0] d,
                                                    input logic [CNT_W-1:0] n);
    logic [DATA_W-1:0] r;
    int src;
    r = '0;
    for (int b = 0; b < DATA_BYTES; b++) begin
      src = int'(n) - 1 - b;
      if (src >= 0) r[b*8 +: 8] = d[src*8 +: 8];
    end
    return r;
  endfunction

  logic [ADDR_W-1:0] addrQ;
  logic [SIZE_W-1:0] sizeQ;
  logic [2:0]        kindQ;
  logic              writeQ;
  logic              chkQ;
  logic              exclQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic [IDX_W-1:0]  idxQ;

  logic [CNT_W-1:0]  reqCnt;
  logic [CNT_W-1:0]  byteCnt;
  logic [IDX_W-1:0]  lowMask;
  logic              aligned;
  logic              isVec;
  logic              isStrict;
  logic [DATA_W-1:0] wdataNext;

  assign reqCnt    = CNT_W'(1) << reqSizeLog;
  assign wdataNext = reqBigEndian ? mirrorLanes(reqWdata, reqCnt)
                                  : keepLanes(reqWdata, reqCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      kindQ  <= '0;
      writeQ <= 1'b0;
      chkQ   <= 1'b0;
      exclQ  <= 1'b0;
      wdataQ <= '0;
    end else if (strobes.load) begin
      addrQ  <= reqAddr;
      sizeQ  <= reqSizeLog;
      kindQ  <= reqKind;
      writeQ <= reqWrite;
      chkQ   <= reqAlignChk;
      exclQ  <= reqExcl;
      wdataQ <= wdataNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (strobes.load) begin
      idxQ <= '0;
    end else if (strobes.incIdx) begin
      idxQ <= idxQ + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strobes.load) begin
      rdataQ <= '0;
    end else if (strobes.capWhole && !writeQ) begin
      rdataQ <= keepLanes(memRdata, byteCnt);
    end else if (strobes.capByte && !writeQ) begin
      rdataQ[{idxQ, 3'b000} +: 8] <= memRdata[7:0];
    end
  end

  // classification of the held request
  assign byteCnt  = CNT_W'(1) << sizeQ;
  assign lowMask  = IDX_W'(byteCnt - CNT_W'(1));
  assign aligned  = (addrQ[IDX_W-1:0] & lowMask) == '0;
  assign isVec    = (kindQ == KIND_VECTOR) || (kindQ == KIND_VSTREAM);
  assign isStrict = (kindQ == KIND_ATOMIC) || (kindQ == KIND_ORDERED);

  assign status.mustFault = !aligned && (isStrict || chkQ);
  assign status.mustSplit = !((aligned && !isVec) || (sizeQ == '0));
  assign status.isExcl    = exclQ;
  assign status.lastByte  = ({1'b0, idxQ} + CNT_W'(1)) == byteCnt;

  // memory port view
  assign memAddr    = strobes.splitMode ? addrQ + ADDR_W'(idxQ) : addrQ;
  assign memWrite   = writeQ;
  assign memSizeLog = strobes.splitMode ? '0 : sizeQ;
  assign memWdata   = strobes.splitMode ? {{(DATA_W-8){1'b0}}, wdataQ[{idxQ, 3'b000} +: 8]}
                                        : wdataQ;

  assign rspRdata = rdataQ;
  assign rspAddr  = addrQ;

  // consecutive split bytes walk upward by one
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incIdx |=> memAddr == $past(memAddr) + ADDR_W'(1));

  // the held address does not move while a request is in flight
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load && !$past(strobes.load) |-> $stable(rspAddr));

endmodule

// File: rtl/ubs_control.sv
`timescale 1ns/1ps
module ubs_control
  import ubs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        rspValid,
  output logic [1:0]  rspCode,
  output logic        memValid,
  input  logic        memReady,
  input  logic        memRspValid,
  input  logic        memRspErr,
  input  dpStatus_t   status,
  output ctlStrobes_t strobes
);

  ctlState_e stateQ, stateD;
  rspCode_e  codeQ, codeD;
  logic      splitQ, splitD;

  always_comb begin
    stateD  = stateQ;
    codeD   = codeQ;
    splitD  = splitQ;
    strobes = '0;
    strobes.splitMode = splitQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.load = 1'b1;
          stateD = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (status.mustFault) begin
          codeD  = RSP_ALIGN;
          stateD = ST_RESP;
        end else if (status.mustSplit && status.isExcl) begin
          codeD  = RSP_EXCL;
          stateD = ST_RESP;
        end else begin
          codeD  = RSP_OK;
          splitD = status.mustSplit;
          stateD = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (memReady) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (memRspErr) begin
            codeD  = RSP_BUS;
            stateD = ST_RESP;
          end else if (!splitQ) begin
            strobes.capWhole = 1'b1;
            stateD = ST_RESP;
          end else begin
            strobes.capByte = 1'b1;
            if (status.lastByte) begin
              stateD = ST_RESP;
            end else begin
              strobes.incIdx = 1'b1;
              stateD = ST_ISSUE;
            end
          end
        end
      end
      ST_RESP: begin
        splitD = 1'b0;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      codeQ  <= RSP_OK;
      splitQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      codeQ  <= codeD;
      splitQ <= splitD;
    end
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign rspValid = (stateQ == ST_RESP);
  assign memValid = (stateQ == ST_ISSUE);
  assign rspCode  = codeQ;

  // an offered transaction stays offered until taken
  assert_hold_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid);

  // no new request while the memory side is busy
  assert_busy_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !reqReady);

  // ready drops only after a request was taken
  assert_accept_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqReady) |-> $past(reqValid));

  // a refused access never touched memory in the cycle before its response
  assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspCode == RSP_ALIGN || rspCode == RSP_EXCL) |-> $past(!memValid));

  // completion is a single-cycle pulse
  assert_one_rsp_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/ubs_top.sv
`timescale 1ns/1ps
module ubs_top
  import ubs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 16,
  parameter int SIZE_W     = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [SIZE_W-1:0]       reqSizeLog,
  input  logic [2:0]              reqKind,
  input  logic                    reqWrite,
  input  logic [DATA_BYTES*8-1:0] reqWdata,
  input  logic                    reqBigEndian,
  input  logic                    reqAlignChk,
  input  logic                    reqExcl,
  output logic                    rspValid,
  output logic [1:0]              rspCode,
  output logic [DATA_BYTES*8-1:0] rspRdata,
  output logic [ADDR_W-1:0]       rspAddr,
  output logic                    memValid,
  input  logic                    memReady,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memWrite,
  output logic [SIZE_W-1:0]       memSizeLog,
  output logic [DATA_BYTES*8-1:0] memWdata,
  input  logic                    memRspValid,
  input  logic                    memRspErr,
  input  logic [DATA_BYTES*8-1:0] memRdata
);

  ctlStrobes_t strobes;
  dpStatus_t   status;

  ubs_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .rspValid    (rspValid),
    .rspCode     (rspCode),
    .memValid    (memValid),
    .memReady    (memReady),
    .memRspValid (memRspValid),
    .memRspErr   (memRspErr),
    .status      (status),
    .strobes     (strobes)
  );

  ubs_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_BYTES (DATA_BYTES),
    .SIZE_W     (SIZE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .status       (status),
    .reqAddr      (reqAddr),
    .reqSizeLog   (reqSizeLog),
    .reqKind      (reqKind),
    .reqWrite     (reqWrite),
    .reqWdata     (reqWdata),
    .reqBigEndian (reqBigEndian),
    .reqAlignChk  (reqAlignChk),
    .reqExcl      (reqExcl),
    .memAddr      (memAddr),
    .memWrite     (memWrite),
    .memSizeLog   (memSizeLog),
    .memWdata     (memWdata),
    .memRdata     (memRdata),
    .rspRdata     (rspRdata),
    .rspAddr      (rspAddr)
  );

endmodule

// File: tb/ubs_top_tb.sv
`timescale 1ns/1ps
module ubs_top_tb;

  localparam int AW = 32;
  localparam int DB = 16;
  localparam int DW = DB * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [2:0]    reqSizeLog = '0;
  logic [2:0]    reqKind = '0;
  logic          reqWrite = 1'b0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqBigEndian = 1'b0;
  logic          reqAlignChk = 1'b0;
  logic          reqExcl = 1'b0;
  logic          rspValid;
  logic [1:0]    rspCode;
  logic [DW-1:0] rspRdata;
  logic [AW-1:0] rspAddr;
  logic          memValid;
  logic          memReady = 1'b1;
  logic [AW-1:0] memAddr;
  logic          memWrite;
  logic [2:0]    memSizeLog;
  logic [DW-1:0] memWdata;
  logic          memRspValid = 1'b0;
  logic          memRspErr = 1'b0;
  logic [DW-1:0] memRdata = '0;

  always #2.5 clk = ~clk;

  ubs_top u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqSizeLog(reqSizeLog), .reqKind(reqKind), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .reqBigEndian(reqBigEndian),
    .reqAlignChk(reqAlignChk), .reqExcl(reqExcl),
    .rspValid(rspValid), .rspCode(rspCode), .rspRdata(rspRdata), .rspAddr(rspAddr),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memWrite(memWrite), .memSizeLog(memSizeLog), .memWdata(memWdata),
    .memRspValid(memRspValid), .memRspErr(memRspErr), .memRdata(memRdata)
  );

  // expectations written by the stimulus task only
  string         curTag = "";
  int            reqSeq = 0;
  int            expN = 0;
  logic [AW-1:0] expTA [DB];
  logic [2:0]    expTS [DB];
  logic          expTW [DB];
  logic [DW-1:0] expTD [DB];
  logic [1:0]    expCode = '0;
  logic [DW-1:0] expRd = '0;
  logic [AW-1:0] expAd = '0;
  logic          errOn = 1'b0;
  logic [AW-1:0] errAt = '0;
  logic          stallOn = 1'b0;
  logic          done = 1'b0;

  // state written by the monitor only
  logic [7:0]    mem [256];
  int            checks = 0;
  int            fails = 0;
  int            rspCnt = 0;
  int            cyc = 0;
  int            rdPtr = 0;
  int            seenSeq = 0;
  logic          outstanding = 1'b0;
  logic          rstSeen = 1'b0;
  logic          pendRsp = 1'b0;
  logic          pendErr = 1'b0;
  logic [DW-1:0] pendData = '0;

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference memory and per-clock comparison
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      memRspValid = 1'b0;
    end else begin
      if (!rstSeen) begin
        chk("R1", "reqReady after reset", DW'(reqReady), DW'(1));
        chk("R1", "memValid after reset", DW'(memValid), DW'(0));
        chk("R1", "rspValid after reset", DW'(rspValid), DW'(0));
        rstSeen = 1'b1;
      end
      if (seenSeq != reqSeq) begin
        seenSeq = reqSeq;
        rdPtr = 0;
      end
      memRspValid = pendRsp;
      memRspErr   = pendErr;
      memRdata    = pendData;
      pendRsp     = 1'b0;
      memReady    = stallOn ? ((cyc % 3) != 1) : 1'b1;

      if (memValid && memReady) begin
        if (rdPtr >= expN) begin
          chk(curTag, "unexpected memory transaction", DW'(memAddr), '1);
        end else begin
          chk(curTag, "transaction address", DW'(memAddr), DW'(expTA[rdPtr]));
          chk(curTag, "transaction size", DW'(memSizeLog), DW'(expTS[rdPtr]));
          chk(curTag, "transaction direction", DW'(memWrite), DW'(expTW[rdPtr]));
          if (expTW[rdPtr]) chk(curTag, "transaction write data", memWdata, expTD[rdPtr]);
          rdPtr++;
        end
        pendRsp  = 1'b1;
        pendErr  = errOn && (memAddr == errAt);
        pendData = '0;
        for (int i = 0; i < (1 << memSizeLog); i++) begin
          if (memWrite && !pendErr) mem[8'(memAddr + AW'(i))] = memWdata[i*8 +: 8];
          if (!memWrite) pendData[i*8 +: 8] = mem[8'(memAddr + AW'(i))];
        end
      end

      if (outstanding && reqReady) chk("R10", "ready while busy", DW'(reqReady), DW'(0));

      if (rspValid) begin
        chk(curTag, "response code", DW'(rspCode), DW'(expCode));
        chk(curTag, "response address", DW'(rspAddr), DW'(expAd));
        if (expCode == 2'd0) chk(curTag, "response data", rspRdata, expRd);
        chk(curTag, "transactions issued before response", DW'(rdPtr), DW'(expN));
        outstanding = 1'b0;
        rspCnt++;
      end
      if (reqValid && reqReady) outstanding = 1'b1;
    end
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // behavioural expectation for one request, then drive it and wait
  task automatic runReq(input string tag, input logic [AW-1:0] a, input int sl,
                        input int kind, input bit wr, input logic [DW-1:0] wd,
                        input bit be, input bit ac, input bit ex,
                        input bit eOn, input logic [AW-1:0] eAt);
    int n;
    bit al, vec, strict, split;
    logic [7:0] wb [DB];
    logic [DW-1:0] whole;
    int start;
    n = 1 << sl;
    al = (a % n) == 0;
    vec = (kind == 3) || (kind == 4);
    strict = (kind == 1) || (kind == 2);
    split = !((al && !vec) || n == 1);
    whole = '0;
    for (int b = 0; b < DB; b++) begin
      wb[b] = (b < n) ? (be ? wd[(n-1-b)*8 +: 8] : wd[b*8 +: 8]) : 8'h00;
      whole[b*8 +: 8] = wb[b];
    end
    expN = 0;
    expRd = '0;
    if (!al && (strict || ac)) expCode = 2'd1;
    else if (split && ex) expCode = 2'd2;
    else begin
      expCode = 2'd0;
      if (!split) begin
        expTA[0] = a; expTS[0] = 3'(sl); expTW[0] = wr; expTD[0] = whole;
        expN = 1;
        if (eOn && a == eAt) expCode = 2'd3;
        if (!wr) for (int i = 0; i < n; i++) expRd[i*8 +: 8] = mem[8'(a + AW'(i))];
      end else begin
        for (int i = 0; i < n; i++) begin
          expTA[i] = a + AW'(i); expTS[i] = 3'd0; expTW[i] = wr;
          expTD[i] = {{(DW-8){1'b0}}, wb[i]};
          expN = i + 1;
          if (!wr) expRd[i*8 +: 8] = mem[8'(a + AW'(i))];
          if (eOn && (a + AW'(i)) == eAt) begin
            expCode = 2'd3;
            break;
          end
        end
      end
    end
    if (wr) expRd = '0;
    expAd = a;
    errOn = eOn;
    errAt = eAt;
    curTag = tag;
    reqSeq++;
    start = rspCnt;
    @(posedge clk); #1;
    reqValid = 1'b1; reqAddr = a; reqSizeLog = 3'(sl); reqKind = 3'(kind);
    reqWrite = wr; reqWdata = wd; reqBigEndian = be; reqAlignChk = ac; reqExcl = ex;
    @(posedge clk); #1;
    reqValid = 1'b0;
    while (rspCnt == start) @(posedge clk);
  endtask

  localparam logic [DW-1:0] PAT = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    // R2: aligned normal read of 8, aligned atomic write of 4
    runReq("R2", 32'h10, 3, 0, 0, '0, 0, 0, 0, 0, '0);
    runReq("R2", 32'h18, 2, 1, 1, PAT, 0, 0, 0, 0, '0);
    // R3: byte-sized vector access at an odd address
    runReq("R3", 32'h21, 0, 3, 0, '0, 0, 0, 0, 0, '0);
    runReq("R3", 32'h23, 0, 4, 1, PAT, 1, 1, 1, 0, '0);
    // R4: unaligned atomic, unaligned normal with check set
    runReq("R4", 32'h22, 2, 1, 0, '0, 0, 0, 0, 0, '0);
    runReq("R4", 32'h25, 1, 0, 1, PAT, 0, 1, 0, 0, '0);
    // R11: multiple of four but not of eight
    runReq("R11", 32'h24, 3, 2, 0, '0, 0, 0, 0, 0, '0);
    runReq("R11", 32'h80, 4, 0, 0, '0, 0, 0, 0, 0, '0);
    // R5: aligned vector write splits; unaligned normal read splits with stalls
    runReq("R5", 32'h30, 2, 3, 1, PAT, 0, 0, 0, 0, '0);
    stallOn = 1'b1;
    runReq("R6", 32'h33, 3, 0, 0, '0, 0, 0, 0, 0, '0);
    // R7: big-endian single write, read back little-endian
    runReq("R7", 32'h40, 2, 0, 1, PAT, 1, 0, 0, 0, '0);
    runReq("R7", 32'h40, 2, 0, 0, '0, 0, 0, 0, 0, '0);
    // R7: big-endian split write of 16 by vector-stream, read back by split read
    runReq("R7", 32'h50, 4, 4, 1, PAT, 1, 0, 0, 0, '0);
    runReq("R7", 32'h51, 3, 3, 0, '0, 0, 0, 0, 0, '0);
    stallOn = 1'b0;
    // R8: exclusive split refused, exclusive single allowed, fault wins
    runReq("R8", 32'h61, 2, 0, 0, '0, 0, 0, 1, 0, '0);
    runReq("R8", 32'h60, 3, 0, 0, '0, 0, 0, 1, 0, '0);
    runReq("R8", 32'h61, 2, 1, 0, '0, 0, 0, 1, 0, '0);
    runReq("R8", 32'h70, 2, 3, 1, PAT, 0, 0, 1, 0, '0);
    // R9: error on third byte of a split read, and on a single write
    runReq("R9", 32'h91, 2, 0, 0, '0, 0, 0, 0, 1, 32'h93);
    runReq("R9", 32'hA0, 3, 0, 1, PAT, 0, 0, 0, 1, 32'hA0);
    runReq("R9", 32'hA0, 3, 0, 0, '0, 0, 0, 0, 0, '0);
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule